// File: doc/BRIEF.md
# Configuration Register Bank with Host Byte Bus

This block is the configuration store of a signal-processing chip. An external processor sees it as an ordinary memory-mapped peripheral. The processor uses an 8-bit address bus, a byte-wide data bus and three active-low strobes: chip enable, read and write. The bank holds 148 byte registers. Each register has a defined power-on value. Their contents are presented side by side on one flat vector that the downstream datapath decodes. The data bus leaves the block as separate output-data and output-enable pins, and the pad ring turns them into a tri-state pin.

The host strobes are not synchronised to the system clock. The block samples them with a single register stage, and a write lands on the first clock edge that sees the write strobe high after the previous edge saw it low with chip enable asserted. Because there is no synchroniser, a register can change while the datapath is using it. Software must therefore issue the chip-wide sync strobe after configuring, before it relies on the new settings. The read path is combinational from the address pins. It behaves like an asynchronous memory read.

A synchronous, active-high master reset returns every register to its default. It discards any pending write, and it holds the data-bus output enable low for as long as it is asserted.

Top module: `cfg_regbank`

## Requirements
- R1: After master reset, register i (0 to 147) holds a byte whose upper nibble is i mod 16 and whose lower nibble is the bitwise inverse of i mod 16. For example, register 10 resets to 8'hA5 and register 147 to 8'h3C.
- R2: A write lands on the first clock edge at which host_wr_n is high while the previous edge saw host_wr_n low and host_ce_n low. The address and data are those present at that previous edge. Holding host_wr_n low changes nothing.
- R3: If host_ce_n was high at the last edge that saw host_wr_n low, the following rise of host_wr_n writes nothing.
- R4: Addresses 148 to 255 read as 8'h00, and writes to them change no register.
- R5: While the read is enabled, host_d_o equals the register addressed by host_a. It follows host_a combinationally, with no clock latency.
- R6: host_d_oe is high exactly when host_ce_n and host_rd_n are both low and mr is low.
- R7: While mr is high, host_d_oe is low and no write lands. A write strobe that was under way when reset came is discarded.
- R8: cfg_flat[8*i+7 : 8*i] always carries register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mr | input | 1 | Master reset, synchronous, active high |
| host_ce_n | input | 1 | Chip enable, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_a | input | 8 | Register address |
| host_d_i | input | 8 | Write data from the pad |
| host_d_o | output | 8 | Read data to the pad |
| host_d_oe | output | 1 | Pad output enable for the data bus |
| cfg_flat | output | 1184 | All registers, register i at bits 8*i+7:8*i |

## Verification
A corrupted register value shows up on cfg_flat on the clock after the faulty update. It also shows up on host_d_o as soon as the host addresses that register. Because the reference model is compared on every clock, a bad write decode, a wrong capture edge or a lost default is reported within one cycle of the event. A wrong enable term shows up on host_d_oe in the same cycle as the strobe pattern that exposes it.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    parameter int unsigned ADDR_W   = 8;
    parameter int unsigned DATA_W   = 8;
    parameter int unsigned NUM_REGS = 148;

    // Host pins as seen at one clock edge
    typedef struct packed {
        logic              ce_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_smp_t;

    // Write request produced by the strobe edge detector
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    localparam host_smp_t HOST_IDLE = '{ce_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};

    // Power-on value of register idx: index nibble over its complement
    function automatic logic [DATA_W-1:0] reg_default(input int unsigned idx);
        logic [3:0] nib;
        nib = idx[3:0];
        return DATA_W'({nib, ~nib});
    endfunction

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return 32'(a) < NUM_REGS;
    endfunction

endpackage

// File: rtl/cfg_host_sampler.sv
module cfg_host_sampler
    import cfg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              mr,
    input  logic              ce_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output wr_req_t           req
);
    // One sampling stage only; no synchroniser chain
    host_smp_t smp_q;

    always_ff @(posedge clk) begin
        if (mr) begin
            smp_q <= HOST_IDLE;
        end else begin
            smp_q <= '{ce_n: ce_n, wr_n: wr_n, addr: addr, data: din};
        end
    end

    // Rising strobe seen now, low strobe with chip enable at last edge
    always_comb begin
        req.valid = !mr && wr_n && !smp_q.wr_n && !smp_q.ce_n;
        req.addr  = smp_q.addr;
        req.data  = smp_q.data;
    end

endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned N_REGS = NUM_REGS,
    localparam int unsigned FLAT_W = N_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              mr,
    input  wr_req_t           req,
    output logic [FLAT_W-1:0] flat
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        logic              hit;

        assign hit = req.valid && (req.addr == ADDR_W'(g));

        always_ff @(posedge clk) begin
            if (mr) begin
                val_q <= reg_default(g);
            end else if (hit) begin
                val_q <= req.data;
            end
        end

        assign flat[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned N_REGS = NUM_REGS,
    localparam int unsigned FLAT_W = N_REGS * DATA_W
) (
    input  logic              mr,
    input  logic              ce_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FLAT_W-1:0] flat,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                sel = flat[i*DATA_W +: DATA_W];
            end
        end
    end

    assign oe   = !mr && !ce_n && !rd_n;
    assign dout = oe ? sel : '0;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned N_REGS = NUM_REGS,
    localparam int unsigned FLAT_W = N_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              mr,
    input  logic              host_ce_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [ADDR_W-1:0] host_a,
    input  logic [DATA_W-1:0] host_d_i,
    output logic [DATA_W-1:0] host_d_o,
    output logic              host_d_oe,
    output logic [FLAT_W-1:0] cfg_flat
);
    wr_req_t wr_req;

    cfg_host_sampler u_smp (
        .clk  (clk),
        .mr   (mr),
        .ce_n (host_ce_n),
        .wr_n (host_wr_n),
        .addr (host_a),
        .din  (host_d_i),
        .req  (wr_req)
    );

    cfg_reg_array #(.N_REGS(N_REGS)) u_regs (
        .clk  (clk),
        .mr   (mr),
        .req  (wr_req),
        .flat (cfg_flat)
    );

    cfg_read_port #(.N_REGS(N_REGS)) u_rd (
        .mr   (mr),
        .ce_n (host_ce_n),
        .rd_n (host_rd_n),
        .addr (host_a),
        .flat (cfg_flat),
        .dout (host_d_o),
        .oe   (host_d_oe)
    );

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned N_REGS = NUM_REGS,
    localparam int unsigned FLAT_W = N_REGS * DATA_W
) (
    input logic              clk,
    input logic              mr,
    input logic              host_ce_n,
    input logic              host_rd_n,
    input logic              host_wr_n,
    input logic [ADDR_W-1:0] host_a,
    input logic [DATA_W-1:0] host_d_i,
    input logic [DATA_W-1:0] host_d_o,
    input logic              host_d_oe,
    input logic [FLAT_W-1:0] cfg_flat
);
    logic              was_mr = 1'b0;
    logic              pv_wr_n = 1'b1;
    logic              pv_ce_n = 1'b1;
    logic [ADDR_W-1:0] pv_a = '0;
    logic [DATA_W-1:0] pv_d = '0;
    logic [FLAT_W-1:0] dflt;
    logic              rise_ok;
    logic              rise_blk;

    always_comb begin
        for (int i = 0; i < N_REGS; i++) begin
            dflt[i*DATA_W +: DATA_W] = reg_default(i);
        end
    end

    always_ff @(posedge clk) begin
        was_mr <= mr;
        if (mr) begin
            pv_wr_n <= 1'b1;
            pv_ce_n <= 1'b1;
        end else begin
            pv_wr_n <= host_wr_n;
            pv_ce_n <= host_ce_n;
        end
        pv_a <= host_a;
        pv_d <= host_d_i;
    end

    assign rise_ok  = host_wr_n && !pv_wr_n && !pv_ce_n;
    assign rise_blk = host_wr_n && !pv_wr_n && pv_ce_n;

    // R1: defaults visible right after reset
    p_default_after_reset_r1: assert property (@(posedge clk) disable iff (mr)
        was_mr |-> cfg_flat == dflt);

    // R2: mapped write lands with the data captured one edge earlier
    p_write_lands_r2: assert property (@(posedge clk) disable iff (mr)
        (rise_ok && addr_mapped(pv_a)) |=>
            cfg_flat[32'($past(pv_a))*DATA_W +: DATA_W] == $past(pv_d));

    // R2: without a qualified rise nothing changes
    p_hold_without_rise_r2: assert property (@(posedge clk) disable iff (mr)
        !rise_ok |=> $stable(cfg_flat));

    // R3: rise with chip enable high writes nothing
    p_no_write_ce_high_r3: assert property (@(posedge clk) disable iff (mr)
        rise_blk |=> $stable(cfg_flat));

    // R4: unmapped writes ignored
    p_unmapped_ignored_r4: assert property (@(posedge clk) disable iff (mr)
        (rise_ok && !addr_mapped(pv_a)) |=> $stable(cfg_flat));

    // R4: unmapped read returns zero
    p_unmapped_reads_zero_r4: assert property (@(posedge clk) disable iff (mr)
        (host_d_oe && !addr_mapped(host_a)) |-> host_d_o == '0);

    // R5: read data follows the addressed register
    p_read_matches_r5: assert property (@(posedge clk) disable iff (mr)
        (host_d_oe && addr_mapped(host_a)) |->
            host_d_o == cfg_flat[32'(host_a)*DATA_W +: DATA_W]);

    // R6: output enable requires both strobes
    p_oe_needs_strobes_r6: assert property (@(posedge clk) disable iff (mr)
        host_d_oe |-> (!host_ce_n && !host_rd_n));

    // R7: no bus drive during master reset
    always_comb begin
        if (mr) begin
            p_oe_off_in_reset_r7: assert (!host_d_oe);
        end
    end

endmodule

bind cfg_regbank cfg_regbank_chk #(.N_REGS(N_REGS)) u_chk (
    .clk       (clk),
    .mr        (mr),
    .host_ce_n (host_ce_n),
    .host_rd_n (host_rd_n),
    .host_wr_n (host_wr_n),
    .host_a    (host_a),
    .host_d_i  (host_d_i),
    .host_d_o  (host_d_o),
    .host_d_oe (host_d_oe),
    .cfg_flat  (cfg_flat)
);

// File: tb/tb_cfg_regbank.sv
`timescale 1ns/1ps
module tb_cfg_regbank;
    localparam int NR = 148;

    logic            clk = 1'b0;
    logic            mr = 1'b1;
    logic            ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]      a = '0, di = '0;
    logic [7:0]      dout;
    logic            oe;
    logic [NR*8-1:0] flat;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    int mdl [NR];
    int l_wr = 1, l_ce = 1, l_a = 0, l_d = 0;

    always #2 clk = ~clk;

    cfg_regbank dut (
        .clk(clk), .mr(mr), .host_ce_n(ce_n), .host_rd_n(rd_n),
        .host_wr_n(wr_n), .host_a(a), .host_d_i(di),
        .host_d_o(dout), .host_d_oe(oe), .cfg_flat(flat)
    );

    function automatic int dflt(int i);
        return ((i % 16) * 16) + (15 - (i % 16));
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock reference model and comparison
    always @(posedge clk) begin
        if (mr) begin
            for (int i = 0; i < NR; i++) mdl[i] = dflt(i);
            l_wr = 1; l_ce = 1;
        end else begin
            if (wr_n == 1'b1 && l_wr == 0 && l_ce == 0 && l_a < NR) mdl[l_a] = l_d;
            l_wr = int'(wr_n); l_ce = int'(ce_n); l_a = int'(a); l_d = int'(di);
        end
        #1;
        begin
            int bad;
            bad = -1;
            for (int i = 0; i < NR; i++)
                if (bad < 0 && int'(flat[i*8 +: 8]) != mdl[i]) bad = i;
            checks++;
            if (bad >= 0) begin
                errors++;
                $display("FAIL R8 cfg_flat byte %0d: actual %0h expected %0h",
                         bad, flat[bad*8 +: 8], mdl[bad]);
            end
            check("R6 output enable", int'(oe), int'(!mr && !ce_n && !rd_n));
            if (!mr && !ce_n && !rd_n)
                check("R5 read data", int'(dout), (int'(a) < NR) ? mdl[a] : 0);
        end
    end

    task automatic do_write(int addr, int data, bit ce_low);
        @(negedge clk);
        ce_n = !ce_low; rd_n = 1; a = 8'(addr); di = 8'(data); wr_n = 0;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1;
        @(negedge clk);
        ce_n = 1;
    endtask

    task automatic do_read(int addr, int exp, string tag);
        @(negedge clk);
        ce_n = 0; rd_n = 0; wr_n = 1; a = 8'(addr);
        @(posedge clk);
        #1;
        check(tag, int'(oe), 1);
        check(tag, int'(dout), exp);
        @(negedge clk);
        ce_n = 1; rd_n = 1;
    endtask

    initial begin
        // R7: no drive during reset even with both strobes low
        repeat (2) @(negedge clk);
        ce_n = 0; rd_n = 0;
        @(posedge clk); #1;
        check("R7 oe in reset", int'(oe), 0);
        @(negedge clk);
        ce_n = 1; rd_n = 1; mr = 0;
        @(negedge clk);

        // R1 defaults, R8 flat slices
        do_read(0, 8'h0F, "R1 default reg0");
        do_read(10, 8'hA5, "R1 default reg10");
        do_read(147, 8'h3C, "R1 default reg147");
        check("R8 flat slice reg5", int'(flat[5*8 +: 8]), 8'h5A);

        // R4 unmapped reads
        do_read(148, 0, "R4 read 148");
        do_read(255, 0, "R4 read 255");

        // R2 writes incl. last mapped address
        do_write(10, 8'h5C, 1);
        do_read(10, 8'h5C, "R2 write reg10");
        do_write(147, 8'hE1, 1);
        do_read(147, 8'hE1, "R2 write reg147");
        do_write(0, 8'h99, 1);
        check("R8 flat slice reg0", int'(flat[7:0]), 8'h99);

        // R4 unmapped write ignored
        do_write(200, 8'hFF, 1);
        do_write(148, 8'h11, 1);
        do_read(200, 0, "R4 read 200 after write");
        do_read(147, 8'hE1, "R4 reg147 untouched");

        // R3 rise with chip enable high
        do_write(20, 8'h77, 0);
        do_read(20, 8'h4B, "R3 reg20 kept default");

        // R2 long low strobe writes nothing until it rises
        @(negedge clk);
        ce_n = 0; a = 8'd30; di = 8'h42; wr_n = 0;
        repeat (8) @(negedge clk);
        check("R2 no write while low", int'(flat[30*8 +: 8]), 8'hE1);
        wr_n = 1;
        @(negedge clk);
        ce_n = 1;
        check("R2 write after rise", int'(flat[30*8 +: 8]), 8'h42);

        // R6 single strobe does not enable the bus
        @(negedge clk);
        ce_n = 0; rd_n = 1;
        @(posedge clk); #1;
        check("R6 ce only", int'(oe), 0);
        @(negedge clk);
        ce_n = 1; rd_n = 0;
        @(posedge clk); #1;
        check("R6 rd only", int'(oe), 0);
        @(negedge clk);
        rd_n = 1;

        // R5 address change during a read is followed combinationally
        @(negedge clk);
        ce_n = 0; rd_n = 0; a = 8'd10;
        #0.5;
        check("R5 comb read a10", int'(dout), 8'h5C);
        a = 8'd1;
        #0.5;
        check("R5 comb read a1", int'(dout), 8'h1E);
        @(negedge clk);
        ce_n = 1; rd_n = 1;

        // R7 reset in the middle of a write strobe discards it
        @(negedge clk);
        ce_n = 0; a = 8'd50; di = 8'hC3; wr_n = 0;
        @(negedge clk);
        mr = 1;
        @(negedge clk);
        wr_n = 1;
        @(negedge clk);
        mr = 0; ce_n = 1;
        @(negedge clk);
        check("R7 write discarded", int'(flat[50*8 +: 8]), 8'h2D);
        do_read(10, 8'hA5, "R1 reg10 default after reset");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule